// File: doc/BRIEF.md
# Time-Triggered Frame Receive Sequencer

This block walks the structure of one frame on a time-triggered automotive bus channel. An upstream sampler hands it one decided bit per `bit_valid` pulse, and a separate marker, `frame_start`, tells it that a transmission start has just ended. The first raw bit that follows the marker is the frame start bit. The block then removes the two in-band bits (a 1 and then a 0) that come before every byte of header, payload and trailer CRC. It assembles the header, streams the payload bytes and captures the 24-bit trailer CRC. It then reads the frame end pair and classifies the frame as static or dynamic from the bits that come after it. It goes back to idle once the idle delimiter has run out.

Every result appears on output registers, together with a strobe that lasts one cycle. A transmission that starts with the wrong three-bit prefix is reported as a collision avoidance symbol. Header rule breaches and a malformed end pair set a sticky error flag. The flag clears on the next frame start. The block does not compute either CRC. Both values are passed on unchecked for a neighbouring checker.

Top module: `fr_frame_rx`

## Requirements
- R1: After reset every strobe output and `rule_err` are 0, and the block ignores bits until `frame_start`.
- R2: After the frame start bit, the two bits that come before each byte of header, payload and trailer CRC are dropped. No strobe comes from them and they never enter any field. A header or CRC bit gives no strobe unless it completes its field.
- R3: If the first three raw bits after `frame_start` are not 1,1,0, `cas_valid` pulses one cycle after the third bit is taken. The block then goes idle and gives no further strobes until the next `frame_start`.
- R4: The 40 header bits arrive in this order: reserved, payload preamble, data-frame (1 = data frame), sync, startup, ID[10:0], length[6:0], header CRC[10:0], cycle[5:0]. Each field arrives MSB first. `hdr_valid` pulses one cycle after the last cycle bit is taken, and all header fields are valid while it is high.
- R5: Exactly twice the length field's value of payload bytes follow the header, each MSB first. `byte_valid` pulses with `byte_data` one cycle after each byte's last bit. A length of 0 gives no byte strobes.
- R6: The 24 bits after the payload, MSB first, appear on `crc_value` with a `crc_valid` pulse one cycle after the last one. No byte start bits follow the trailer CRC.
- R7: The two bits after the trailer CRC must be 1 then 0. Any other pair sets `rule_err`.
- R8: If the bit after the end pair is 1, the frame is static and that bit is the first idle-delimiter bit. If it is 0, the frame is dynamic, and a trailing run of 0s lasts until the first 1, which is not counted as a delimiter bit.
- R9: After 11 delimiter bits `done_valid` pulses, with `done_dynamic` giving the class from R8. The block is then idle, and further bits give no strobes.
- R10: A header whose ID is 0 sets `rule_err` by the cycle in which `hdr_valid` is high.
- R11: A header with startup set and sync clear sets `rule_err` by the cycle in which `hdr_valid` is high.
- R12: `rule_err` stays set until `frame_start`, and is 0 in the cycle after it. `frame_start` abandons any frame in progress, and the next raw bit is taken as a frame start bit.
- R13: At most one of the five strobes is high in any cycle. Each strobe lasts one cycle and comes after a cycle in which `bit_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Marks the end of a transmission start; the next raw bit is the frame start bit |
| bit_valid | input | 1 | A sampled raw bit is present on `bit_in` |
| bit_in | input | 1 | Sampled raw bit value |
| hdr_valid | output | 1 | Header fields valid (one cycle) |
| hdr_reserved | output | 1 | Reserved bit |
| hdr_ppi | output | 1 | Payload preamble bit |
| hdr_data_frame | output | 1 | 1 = data frame, 0 = null frame |
| hdr_sync | output | 1 | Sync indicator |
| hdr_startup | output | 1 | Startup indicator |
| hdr_id | output | 11 | Frame ID |
| hdr_len | output | 7 | Payload length in 16-bit words |
| hdr_hcrc | output | 11 | Received header CRC |
| hdr_cycle | output | 6 | Cycle count |
| byte_valid | output | 1 | Payload byte valid (one cycle) |
| byte_data | output | 8 | Payload byte |
| crc_valid | output | 1 | Trailer CRC valid (one cycle) |
| crc_value | output | 24 | Received trailer CRC |
| done_valid | output | 1 | Idle delimiter completed (one cycle) |
| done_dynamic | output | 1 | 1 = dynamic frame, 0 = static |
| cas_valid | output | 1 | Collision avoidance symbol seen (one cycle) |
| rule_err | output | 1 | Sticky rule-violation flag |

## Verification
Every result of this block is registered once. Each strobe therefore appears exactly one cycle after the clock edge that takes the bit completing its field, and it is gone one cycle later. The bench presents each raw bit for one cycle, followed by an empty cycle. On the falling edge after the bit is taken, it compares all five strobes, and any field values, against the event its frame model attached to that bit. On the falling edge after the empty cycle, it requires every strobe to be 0. The flag cleared by `frame_start` is checked one cycle after the marker. The error state is compared when the header completes, when the delimiter completes, and again in idle.

// File: rtl/fr_rx_pkg.sv
package fr_rx_pkg;

    localparam int ID_W   = 11;
    localparam int LEN_W  = 7;
    localparam int HCRC_W = 11;
    localparam int CYC_W  = 6;
    localparam int IND_W  = 5;
    localparam int CRC_W  = 24;
    localparam int BYTE_W = 8;
    localparam int MARK_W = 2;
    localparam int HDR_W  = IND_W + ID_W + LEN_W + HCRC_W + CYC_W;
    localparam int SLOT_W = MARK_W + BYTE_W;

    // Field order equals transmission order, first bit at the MSB.
    typedef struct packed {
        logic              reserved;
        logic              ppi;
        logic              data_frame;
        logic              sync;
        logic              startup;
        logic [ID_W-1:0]   id;
        logic [LEN_W-1:0]  len;
        logic [HCRC_W-1:0] hcrc;
        logic [CYC_W-1:0]  cycle;
    } hdr_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FSS,
        ST_HDR,
        ST_PAY,
        ST_CRC,
        ST_END1,
        ST_END2,
        ST_TAIL,
        ST_DTS,
        ST_CID
    } rx_state_e;

    function automatic logic hdr_breaks_rules(input hdr_t h);
        return (h.id == '0) || (h.startup && !h.sync);
    endfunction

    // States in which byte start bits are inserted by the sender.
    function automatic logic byte_framed(input rx_state_e s);
        return (s == ST_HDR) || (s == ST_PAY) || (s == ST_CRC);
    endfunction

endpackage

// File: rtl/fr_bss_strip.sv
module fr_bss_strip #(
    parameter int SLOT = 10,
    parameter int MARK = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic raw_valid,
    input  logic bypass,
    output logic mark_hit,
    output logic mark_second,
    output logic data_take
);
    localparam int PH_W = $clog2(SLOT);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (raw_valid && !bypass) begin
            phase_q <= (phase_q == PH_W'(SLOT - 1)) ? '0 : phase_q + 1'b1;
        end
    end

    assign mark_hit    = raw_valid && !bypass && (phase_q < PH_W'(MARK));
    assign mark_second = (phase_q == PH_W'(MARK - 1));
    assign data_take   = raw_valid && (bypass || (phase_q >= PH_W'(MARK)));

endmodule

// File: rtl/fr_shift_acc.sv
module fr_shift_acc #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] nxt
);
    logic [W-1:0] acc_q;

    assign nxt = {acc_q[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= nxt;
        end
    end

endmodule

// File: rtl/fr_frame_rx.sv
module fr_frame_rx
    import fr_rx_pkg::*;
#(
    parameter int CID_LEN = 11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frame_start,
    input  logic                bit_valid,
    input  logic                bit_in,
    output logic                hdr_valid,
    output logic                hdr_reserved,
    output logic                hdr_ppi,
    output logic                hdr_data_frame,
    output logic                hdr_sync,
    output logic                hdr_startup,
    output logic [ID_W-1:0]     hdr_id,
    output logic [LEN_W-1:0]    hdr_len,
    output logic [HCRC_W-1:0]   hdr_hcrc,
    output logic [CYC_W-1:0]    hdr_cycle,
    output logic                byte_valid,
    output logic [BYTE_W-1:0]   byte_data,
    output logic                crc_valid,
    output logic [CRC_W-1:0]    crc_value,
    output logic                done_valid,
    output logic                done_dynamic,
    output logic                cas_valid,
    output logic                rule_err
);
    localparam int CNT_MAX = (HDR_W > CID_LEN) ? HDR_W : CID_LEN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int PAY_W   = LEN_W + 1;

    rx_state_e          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [PAY_W-1:0]   pay_left_q;
    logic               fss_ok_q;
    logic               mark_hi_q;
    logic               dyn_q;
    hdr_t               hdr_q;

    logic               bypass;
    logic               mark_hit;
    logic               mark_second;
    logic               data_take;
    logic               shift_en;
    logic [HDR_W-1:0]   sh_nxt;
    hdr_t               hdr_nxt;

    assign bypass   = !byte_framed(state_q);
    assign shift_en = data_take && byte_framed(state_q);
    assign hdr_nxt  = hdr_t'(sh_nxt);

    fr_bss_strip #(
        .SLOT (SLOT_W),
        .MARK (MARK_W)
    ) u_strip (
        .clk         (clk),
        .rst         (rst),
        .restart     (frame_start),
        .raw_valid   (bit_valid),
        .bypass      (bypass),
        .mark_hit    (mark_hit),
        .mark_second (mark_second),
        .data_take   (data_take)
    );

    fr_shift_acc #(
        .W (HDR_W)
    ) u_acc (
        .clk (clk),
        .rst (rst),
        .en  (shift_en),
        .din (bit_in),
        .nxt (sh_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            cnt_q        <= '0;
            pay_left_q   <= '0;
            fss_ok_q     <= 1'b0;
            mark_hi_q    <= 1'b0;
            dyn_q        <= 1'b0;
            hdr_q        <= '0;
            hdr_valid    <= 1'b0;
            byte_valid   <= 1'b0;
            byte_data    <= '0;
            crc_valid    <= 1'b0;
            crc_value    <= '0;
            done_valid   <= 1'b0;
            done_dynamic <= 1'b0;
            cas_valid    <= 1'b0;
            rule_err     <= 1'b0;
        end else begin
            hdr_valid  <= 1'b0;
            byte_valid <= 1'b0;
            crc_valid  <= 1'b0;
            done_valid <= 1'b0;
            cas_valid  <= 1'b0;
            if (frame_start) begin
                state_q  <= ST_FSS;
                cnt_q    <= '0;
                rule_err <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                    end
                    ST_FSS: begin
                        if (bit_valid) begin
                            fss_ok_q <= bit_in;
                            cnt_q    <= '0;
                            state_q  <= ST_HDR;
                        end
                    end
                    ST_HDR: begin
                        if (mark_hit && (cnt_q == '0)) begin
                            if (!mark_second) begin
                                mark_hi_q <= bit_in;
                            end else if (!(fss_ok_q && mark_hi_q && !bit_in)) begin
                                cas_valid <= 1'b1;
                                state_q   <= ST_IDLE;
                            end
                        end
                        if (data_take) begin
                            if (cnt_q == CNT_W'(HDR_W - 1)) begin
                                hdr_valid  <= 1'b1;
                                hdr_q      <= hdr_nxt;
                                pay_left_q <= {hdr_nxt.len, 1'b0};
                                cnt_q      <= '0;
                                state_q    <= (hdr_nxt.len == '0) ? ST_CRC : ST_PAY;
                                if (hdr_breaks_rules(hdr_nxt)) begin
                                    rule_err <= 1'b1;
                                end
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_PAY: begin
                        if (data_take) begin
                            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                                byte_valid <= 1'b1;
                                byte_data  <= sh_nxt[BYTE_W-1:0];
                                cnt_q      <= '0;
                                pay_left_q <= pay_left_q - 1'b1;
                                if (pay_left_q == PAY_W'(1)) begin
                                    state_q <= ST_CRC;
                                end
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_CRC: begin
                        if (data_take) begin
                            if (cnt_q == CNT_W'(CRC_W - 1)) begin
                                crc_valid <= 1'b1;
                                crc_value <= sh_nxt[CRC_W-1:0];
                                cnt_q     <= '0;
                                state_q   <= ST_END1;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_END1: begin
                        if (bit_valid) begin
                            if (!bit_in) begin
                                rule_err <= 1'b1;
                            end
                            state_q <= ST_END2;
                        end
                    end
                    ST_END2: begin
                        if (bit_valid) begin
                            if (bit_in) begin
                                rule_err <= 1'b1;
                            end
                            state_q <= ST_TAIL;
                        end
                    end
                    ST_TAIL: begin
                        if (bit_valid) begin
                            if (bit_in) begin
                                dyn_q   <= 1'b0;
                                cnt_q   <= CNT_W'(1);
                                state_q <= ST_CID;
                            end else begin
                                dyn_q   <= 1'b1;
                                state_q <= ST_DTS;
                            end
                        end
                    end
                    ST_DTS: begin
                        if (bit_valid && bit_in) begin
                            cnt_q   <= '0;
                            state_q <= ST_CID;
                        end
                    end
                    ST_CID: begin
                        if (bit_valid) begin
                            if (cnt_q == CNT_W'(CID_LEN - 1)) begin
                                done_valid   <= 1'b1;
                                done_dynamic <= dyn_q;
                                state_q      <= ST_IDLE;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign hdr_reserved   = hdr_q.reserved;
    assign hdr_ppi        = hdr_q.ppi;
    assign hdr_data_frame = hdr_q.data_frame;
    assign hdr_sync       = hdr_q.sync;
    assign hdr_startup    = hdr_q.startup;
    assign hdr_id         = hdr_q.id;
    assign hdr_len        = hdr_q.len;
    assign hdr_hcrc       = hdr_q.hcrc;
    assign hdr_cycle      = hdr_q.cycle;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hdr_valid, byte_valid, crc_valid, done_valid, cas_valid})); // R13

    AST_STROBE_AFTER_BIT: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid || byte_valid || crc_valid || done_valid || cas_valid) |-> $past(bit_valid)); // R13

    AST_ID_ZERO_ERR: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && (hdr_id == '0)) |-> rule_err); // R10

    AST_STARTUP_ERR: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && hdr_startup && !hdr_sync) |-> rule_err); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rule_err && !frame_start) |=> rule_err); // R12

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !rule_err); // R12

endmodule

// File: tb/tb_fr_frame_rx.sv
module tb_fr_frame_rx;
    import fr_rx_pkg::*;

    localparam int EV_NONE = 0;
    localparam int EV_HDR  = 1;
    localparam int EV_BYTE = 2;
    localparam int EV_CRC  = 3;
    localparam int EV_DONE = 4;
    localparam int EV_CAS  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;

    logic              hdr_valid, hdr_reserved, hdr_ppi, hdr_data_frame, hdr_sync, hdr_startup;
    logic [ID_W-1:0]   hdr_id;
    logic [LEN_W-1:0]  hdr_len;
    logic [HCRC_W-1:0] hdr_hcrc;
    logic [CYC_W-1:0]  hdr_cycle;
    logic              byte_valid;
    logic [7:0]        byte_data;
    logic              crc_valid;
    logic [CRC_W-1:0]  crc_value;
    logic              done_valid, done_dynamic, cas_valid, rule_err;

    always #10 clk = ~clk;

    fr_frame_rx dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .bit_valid(bit_valid), .bit_in(bit_in),
        .hdr_valid(hdr_valid), .hdr_reserved(hdr_reserved), .hdr_ppi(hdr_ppi),
        .hdr_data_frame(hdr_data_frame), .hdr_sync(hdr_sync), .hdr_startup(hdr_startup),
        .hdr_id(hdr_id), .hdr_len(hdr_len), .hdr_hcrc(hdr_hcrc), .hdr_cycle(hdr_cycle),
        .byte_valid(byte_valid), .byte_data(byte_data), .crc_valid(crc_valid),
        .crc_value(crc_value), .done_valid(done_valid), .done_dynamic(done_dynamic),
        .cas_valid(cas_valid), .rule_err(rule_err)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic        raw_q[$];
    int          ev_q[$];
    logic [7:0]  exp_bytes[$];
    logic [39:0] exp_hdr;
    logic [23:0] exp_crc;
    logic        exp_dyn;
    logic        exp_err_hdr;
    logic        exp_err_done;
    logic        exp_fes_bad;
    int          byte_idx;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] strobes();
        return {hdr_valid, byte_valid, crc_valid, done_valid, cas_valid};
    endfunction

    function automatic logic [4:0] ev_vec(input int ev);
        case (ev)
            EV_HDR:  return 5'b10000;
            EV_BYTE: return 5'b01000;
            EV_CRC:  return 5'b00100;
            EV_DONE: return 5'b00010;
            EV_CAS:  return 5'b00001;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic string ev_req(input int ev);
        case (ev)
            EV_HDR:  return "R4";
            EV_BYTE: return "R5";
            EV_CRC:  return "R6";
            EV_DONE: return "R9";
            EV_CAS:  return "R3";
            default: return "R2";
        endcase
    endfunction

    task automatic push_bits(input logic [39:0] v, input int n, input int ev);
        for (int i = n - 1; i >= 0; i--) begin
            raw_q.push_back(v[i]);
            ev_q.push_back((i == 0) ? ev : EV_NONE);
        end
    endtask

    task automatic push_byte(input logic [7:0] b, input int ev);
        push_bits(40'h2, 2, EV_NONE);
        push_bits({32'h0, b}, 8, ev);
    endtask

    task automatic clear_model();
        raw_q.delete();
        ev_q.delete();
        exp_bytes.delete();
        byte_idx = 0;
    endtask

    // dts < 0 : static frame; otherwise number of 0 bits after the end pair
    task automatic build_frame(input logic [31:0] id, input logic [31:0] len, input logic sy,
                               input logic su, input logic [31:0] cyc, input logic fes_bad,
                               input int dts);
        logic [10:0] hcrc;
        logic [7:0]  b;
        clear_model();
        hcrc    = 11'(id * 3 + 5);
        exp_hdr = {1'b0, 1'b1, 1'b1, sy, su, id[10:0], len[6:0], hcrc, cyc[5:0]};
        exp_crc = 24'hB1C000 ^ {13'h0, id[10:0]};
        exp_dyn = (dts >= 0);
        exp_fes_bad  = fes_bad;
        exp_err_hdr  = (id[10:0] == 11'h0) || (su && !sy);
        exp_err_done = exp_err_hdr || fes_bad;
        push_bits(40'h1, 1, EV_NONE);
        for (int k = 0; k < 5; k++)
            push_byte(exp_hdr[39 - 8 * k -: 8], (k == 4) ? EV_HDR : EV_NONE);
        for (int i = 0; i < 2 * int'(len[6:0]); i++) begin
            b = 8'(i * 37 + int'(id) + 3);
            exp_bytes.push_back(b);
            push_byte(b, EV_BYTE);
        end
        for (int k = 0; k < 3; k++)
            push_byte(exp_crc[23 - 8 * k -: 8], (k == 2) ? EV_CRC : EV_NONE);
        push_bits(fes_bad ? 40'h3 : 40'h2, 2, EV_NONE);
        if (dts < 0) begin
            push_bits(40'h7FF, 11, EV_DONE);
        end else begin
            push_bits(40'h0, dts, EV_NONE);
            push_bits(40'h1, 1, EV_NONE);
            push_bits(40'h7FF, 11, EV_DONE);
        end
    endtask

    task automatic run_bits(input bit do_start, input int max_bits);
        int ev;
        if (do_start) begin
            @(negedge clk);
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
            chk("R12", "error clear after start", rule_err, 0);
        end
        for (int idx = 0; idx < raw_q.size() && idx < max_bits; idx++) begin
            ev = ev_q[idx];
            bit_in    = raw_q[idx];
            bit_valid = 1'b1;
            @(negedge clk);
            bit_valid = 1'b0;
            chk(ev_req(ev), $sformatf("strobes at raw bit %0d", idx), strobes(), ev_vec(ev));
            if (ev == EV_HDR) begin
                chk("R4", "reserved", hdr_reserved, exp_hdr[39]);
                chk("R4", "preamble", hdr_ppi, exp_hdr[38]);
                chk("R4", "data frame", hdr_data_frame, exp_hdr[37]);
                chk("R4", "sync", hdr_sync, exp_hdr[36]);
                chk("R4", "startup", hdr_startup, exp_hdr[35]);
                chk("R4", "id", hdr_id, exp_hdr[34:24]);
                chk("R4", "length", hdr_len, exp_hdr[23:17]);
                chk("R4", "header crc", hdr_hcrc, exp_hdr[16:6]);
                chk("R4", "cycle", hdr_cycle, exp_hdr[5:0]);
                chk(exp_err_hdr ? "R10 R11" : "R4", "error at header", rule_err, exp_err_hdr);
            end
            if (ev == EV_BYTE) begin
                chk("R5", $sformatf("payload byte %0d", byte_idx), byte_data, exp_bytes[byte_idx]);
                byte_idx++;
            end
            if (ev == EV_CRC) chk("R6", "trailer crc", crc_value, exp_crc);
            if (ev == EV_DONE) begin
                chk("R8", "dynamic class", done_dynamic, exp_dyn);
                chk(exp_fes_bad ? "R7" : "R12", "error at done", rule_err, exp_err_done);
            end
            @(negedge clk);
            chk("R13", "strobes in gap", strobes(), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "strobes in reset", strobes(), 0);
        chk("R1", "error in reset", rule_err, 0);
        rst = 1'b0;
        // bits before any frame start are ignored
        clear_model();
        push_bits(40'h2AB, 10, EV_NONE);
        run_bits(1'b0, 100);
        chk("R1", "error idle", rule_err, 0);

        // static frame, two words
        build_frame(5, 2, 1'b1, 1'b1, 7, 1'b0, -1);
        run_bits(1'b1, 100000);
        // idle after delimiter: more bits give nothing
        clear_model();
        push_bits(40'h0D6F, 16, EV_NONE);
        run_bits(1'b0, 100);

        // dynamic frame, empty payload, all-ones ID and cycle
        build_frame(11'h7FF, 0, 1'b1, 1'b0, 63, 1'b0, 3);
        run_bits(1'b1, 100000);

        // dynamic frame with a single zero trailing bit
        build_frame(300, 1, 1'b0, 1'b0, 1, 1'b0, 1);
        run_bits(1'b1, 100000);

        // ID zero, error stays set after the frame
        build_frame(0, 1, 1'b1, 1'b0, 2, 1'b0, -1);
        run_bits(1'b1, 100000);
        chk("R12", "error held in idle", rule_err, 1);

        // startup without sync
        build_frame(17, 1, 1'b0, 1'b1, 3, 1'b0, -1);
        run_bits(1'b1, 100000);

        // malformed end pair
        build_frame(33, 1, 1'b1, 1'b0, 4, 1'b1, -1);
        run_bits(1'b1, 100000);
        chk("R7", "error held after bad end pair", rule_err, 1);

        // collision avoidance symbol: third bit high
        clear_model();
        push_bits(40'h7, 3, EV_CAS);
        push_bits(40'h2AAA, 14, EV_NONE);
        run_bits(1'b1, 100);

        // collision avoidance symbol: start bit low
        clear_model();
        push_bits(40'h2, 3, EV_CAS);
        push_bits(40'h3FF, 10, EV_NONE);
        run_bits(1'b1, 100);

        // abandoned frame followed by a full one
        build_frame(9, 3, 1'b1, 1'b0, 12, 1'b0, -1);
        run_bits(1'b1, 60);
        build_frame(44, 1, 1'b1, 1'b0, 13, 1'b0, 2);
        run_bits(1'b1, 100000);

        // largest payload
        build_frame(1000, 127, 1'b1, 1'b0, 20, 1'b0, -1);
        run_bits(1'b1, 100000);
        chk("R5", "byte count at maximum length", byte_idx, 254);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule